// File: doc/BRIEF.md
# Fibonacci-Weighted Codeword Decoder

This block turns a received codeword back into the plain unsigned number it carries. The codeword comes from a bus code that never lets two neighbouring wires switch in opposite directions. Each bit of the codeword carries a Fibonacci weight instead of a power of two. The decoder adds the weights of the bits that are set. It is a tree of plain adders with constant leaf terms and uses no multiplier.

A codeword arrives with a valid strobe. After an optional output register, the result leaves with its own valid strobe. The result has N bits. A range flag goes high when the weighted sum does not fit in N bits, which can only happen for a word that no encoder would send. With the defaults, a 7-bit codeword maps onto a 5-bit value.

Top module: `fib_cw_decoder`

## Requirements
- R1: Codeword bit k (bit 0 is the LSB) has weight f(k+1). The sequence starts f(1)=f(2)=1, and each later term is the sum of the two before it. With M=7 the weights from bit 0 up are 1,1,2,3,5,8,13.
- R2: The result is the sum of the weights of all set bits, taken modulo 2^N. For example, the word 1010001 (bit 6 down to bit 0) gives 13+5+1 = 19, and the all-zero word gives 0.
- R3: `dec_range_err` is 1 exactly when that sum is above 2^N-1. In that case `dec_value` carries the low N bits of the sum.
- R4: The all-ones codeword has the largest sum, f(M+2)-1. With M=7, N=5 this is 33, so the flag is set and `dec_value` is 1.
- R5: With the output register on, `dec_valid` equals `cw_valid` delayed by one clock. The value and flag for a word appear in the same cycle as its delayed valid.
- R6: A synchronous active-high `rst` clears `dec_valid` on the next edge, whatever `cw_valid` is.
- R7: While `cw_valid` is low, `dec_value` and `dec_range_err` keep the result of the last accepted word, even if `cw_word` changes.
- R8: Every value from 0 to 2^N-1, encoded by the stage-by-stage subtract-and-compare encoder, decodes back to itself with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Codeword strobe |
| cw_word | input | M | Received codeword |
| dec_valid | output | 1 | Result strobe |
| dec_value | output | N | Decoded value (low N bits of the sum) |
| dec_range_err | output | 1 | Sum above 2^N-1 |

## Verification
The checker assumes that `cw_valid` and `cw_word` carry defined levels on every clock edge outside reset. It also assumes that any word may arrive, including words no encoder would produce, since the range flag must cover them as well. The stimulus changes inputs only on the falling edge, sweeps all 2^M words, and also replays every encoder output for 0 to 2^N-1. It also idles the strobe while changing the word, and raises reset while the strobe is high, so that the hold and clear properties are exercised under the conditions they assume.

// File: rtl/fibdec_pkg.sv
package fibdec_pkg;

    // f(0)=0, f(1)=f(2)=1, f(k)=f(k-1)+f(k-2)
    function automatic int unsigned fib_num(input int unsigned k);
        int unsigned a;
        int unsigned b;
        int unsigned t;
        a = 0;
        b = 1;
        for (int unsigned i = 0; i < k; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    // Bits needed to hold the largest weighted sum, f(m+2)-1
    function automatic int unsigned sum_width(input int unsigned m);
        return $clog2(fib_num(m + 2));
    endfunction

endpackage

// File: rtl/fibdec_term_gen.sv
module fibdec_term_gen #(
    parameter int M = 7,
    parameter int W = 6
) (
    input  logic [M-1:0]        word,
    output logic [M-1:0][W-1:0] terms
);
    import fibdec_pkg::*;

    for (genvar k = 0; k < M; k++) begin : g_term
        localparam logic [W-1:0] WT = W'(fib_num(k + 1));
        assign terms[k] = word[k] ? WT : '0;
    end

endmodule

// File: rtl/fibdec_sum_tree.sv
module fibdec_sum_tree #(
    parameter int N_IN = 7,
    parameter int W    = 6
) (
    input  logic [N_IN-1:0][W-1:0] terms,
    output logic [W-1:0]           total
);
    localparam int LVL = $clog2(N_IN);
    localparam int P   = 1 << LVL;

    logic [W-1:0] node [1:2*P-1];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N_IN) begin : g_real
            assign node[P+i] = terms[i];
        end else begin : g_pad
            assign node[P+i] = '0;
        end
    end

    for (genvar j = 1; j < P; j++) begin : g_add
        assign node[j] = node[2*j] + node[2*j+1];
    end

    assign total = node[1];

endmodule

// File: rtl/fibdec_out_stage.sv
module fibdec_out_stage #(
    parameter int N       = 5,
    parameter int W       = 6,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_sum,
    output logic         out_valid,
    output logic [N-1:0] out_value,
    output logic         out_err
);
    typedef struct packed {
        logic         err;
        logic [N-1:0] value;
    } result_t;

    result_t res_c;

    always_comb begin
        res_c.err   = (in_sum >> N) != '0;
        res_c.value = N'(in_sum);
    end

    if (OUT_REG) begin : g_reg
        result_t res_q;
        logic    vld_q;

        always_ff @(posedge clk) begin
            if (rst) vld_q <= 1'b0;
            else     vld_q <= in_valid;
        end

        always_ff @(posedge clk) begin
            if (in_valid) res_q <= res_c;
        end

        assign out_valid = vld_q;
        assign out_value = res_q.value;
        assign out_err   = res_q.err;
    end else begin : g_comb
        assign out_valid = in_valid & ~rst;
        assign out_value = res_c.value;
        assign out_err   = res_c.err;
    end

endmodule

// File: rtl/fib_cw_decoder.sv
module fib_cw_decoder #(
    parameter int M       = 7,
    parameter int N       = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cw_valid,
    input  logic [M-1:0] cw_word,
    output logic         dec_valid,
    output logic [N-1:0] dec_value,
    output logic         dec_range_err
);
    import fibdec_pkg::*;

    localparam int SW = sum_width(M);

    logic [M-1:0][SW-1:0] terms;
    logic [SW-1:0]        total;

    fibdec_term_gen #(.M(M), .W(SW)) u_terms (
        .word  (cw_word),
        .terms (terms)
    );

    fibdec_sum_tree #(.N_IN(M), .W(SW)) u_tree (
        .terms (terms),
        .total (total)
    );

    fibdec_out_stage #(.N(N), .W(SW), .OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cw_valid),
        .in_sum    (total),
        .out_valid (dec_valid),
        .out_value (dec_value),
        .out_err   (dec_range_err)
    );

endmodule

// File: rtl/fib_cw_decoder_chk.sv
module fib_cw_decoder_chk #(
    parameter int M       = 7,
    parameter int N       = 5,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         cw_valid,
    input logic [M-1:0] cw_word,
    input logic         dec_valid,
    input logic [N-1:0] dec_value,
    input logic         dec_range_err
);
    import fibdec_pkg::*;

    int unsigned  ref_total;
    logic [N-1:0] ref_low;
    logic         ref_over;

    always_comb begin
        ref_total = 0;
        for (int k = 0; k < M; k++) begin
            if (cw_word[k]) ref_total = ref_total + fib_num(k + 1);
        end
        ref_low  = N'(ref_total);
        ref_over = (ref_total >> N) != 0;
    end

    if (OUT_REG) begin : g_seq
        // R6: reset clears the strobe
        assert_rst_clear_R6: assert property (@(posedge clk)
            rst |=> !dec_valid);

        // R5: one-cycle strobe delay
        assert_valid_lat_R5: assert property (@(posedge clk) disable iff (rst)
            cw_valid |=> dec_valid);
        assert_idle_lat_R5: assert property (@(posedge clk) disable iff (rst)
            !cw_valid |=> !dec_valid);

        // R2: weighted sum of the accepted word
        assert_sum_R2: assert property (@(posedge clk) disable iff (rst)
            cw_valid |=> dec_value == $past(ref_low));

        // R3: range flag
        assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
            cw_valid |=> dec_range_err == $past(ref_over));

        // R7: hold while idle
        assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !cw_valid |=> $stable(dec_value) && $stable(dec_range_err));
    end

endmodule

bind fib_cw_decoder fib_cw_decoder_chk #(.M(M), .N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cw_valid      (cw_valid),
    .cw_word       (cw_word),
    .dec_valid     (dec_valid),
    .dec_value     (dec_value),
    .dec_range_err (dec_range_err)
);

// File: tb/fib_cw_decoder_tb.sv
module fib_cw_decoder_tb;
    localparam int M = 7;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cw_valid = 1'b0;
    logic [M-1:0] cw_word = '0;
    logic         dec_valid;
    logic [N-1:0] dec_value;
    logic         dec_range_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    fib_cw_decoder #(.M(M), .N(N), .OUT_REG(1'b1)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .cw_valid      (cw_valid),
        .cw_word       (cw_word),
        .dec_valid     (dec_valid),
        .dec_value     (dec_value),
        .dec_range_err (dec_range_err)
    );

    function automatic int tb_fib(input int k);
        int x = 0;
        int y = 1;
        int t;
        for (int i = 0; i < k; i++) begin
            t = x + y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int tb_sum(input logic [M-1:0] w);
        int s = 0;
        for (int k = 0; k < M; k++) if (w[k]) s += tb_fib(k + 1);
        return s;
    endfunction

    // stage-wise subtract-and-compare encoder
    function automatic logic [M-1:0] tb_enc(input int v);
        logic [M-1:0] d = '0;
        int r = v;
        int thr;
        for (int k = M; k >= 2; k--) begin
            thr = (k % 2 == 1) ? tb_fib(k) : tb_fib(k + 1);
            if (r >= thr) begin
                d[k-1] = 1'b1;
                r -= tb_fib(k);
            end
        end
        d[0] = r[0];
        return d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [M-1:0] w);
        cw_valid = v;
        cw_word  = w;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        int s;
        logic [M-1:0] w;
        @(negedge clk);
        // R6: reset holds strobe low while input strobe is high
        step(1'b1, '1);
        step(1'b1, '1);
        chk("R6 reset valid", dec_valid, 0);
        rst = 1'b0;

        // R1: each weight alone
        for (int k = 0; k < M; k++) begin
            step(1'b1, M'(1) << k);
            chk("R1 weight", dec_value, tb_fib(k + 1) % (1 << N));
        end

        // R2: worked example and zero
        step(1'b1, 7'b1010001);
        chk("R2 example", dec_value, 19);
        chk("R3 example flag", dec_range_err, 0);
        step(1'b1, '0);
        chk("R2 zero", dec_value, 0);

        // R2/R3: every codeword
        for (int i = 0; i < (1 << M); i++) begin
            w = M'(i);
            step(1'b1, w);
            s = tb_sum(w);
            chk("R2 sweep", dec_value, s % (1 << N));
            chk("R3 sweep flag", dec_range_err, (s > (1 << N) - 1) ? 1 : 0);
        end

        // R4: all ones
        step(1'b1, '1);
        chk("R4 max value", dec_value, (tb_fib(M + 2) - 1) % (1 << N));
        chk("R4 max flag", dec_range_err, 1);

        // R5: strobe latency
        step(1'b1, 7'b0000101);
        chk("R5 valid high", dec_valid, 1);
        chk("R5 value", dec_value, 3);
        step(1'b0, 7'b0000101);
        chk("R5 valid low", dec_valid, 0);

        // R7: hold while idle
        step(1'b1, 7'b1010001);
        step(1'b0, '1);
        chk("R7 hold value", dec_value, 19);
        chk("R7 hold flag", dec_range_err, 0);
        step(1'b0, 7'b0100000);
        chk("R7 hold value 2", dec_value, 19);

        // R6: mid-run reset with strobe high
        step(1'b1, 7'b0000001);
        chk("R6 pre-reset valid", dec_valid, 1);
        rst = 1'b1;
        step(1'b1, 7'b0000001);
        chk("R6 mid reset valid", dec_valid, 0);
        rst = 1'b0;

        // R8: round trip
        for (int v = 0; v < (1 << N); v++) begin
            step(1'b1, tb_enc(v));
            chk("R8 round trip", dec_value, v);
            chk("R8 round trip flag", dec_range_err, 0);
        end
        step(1'b0, '0);

        summary();
        $finish;
    end

endmodule